// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive. After reset it waits out a power-on pause, then runs a burst of wake-up refresh cycles. Only after that burst does it let the host side begin accesses. In normal operation a prescaled interval timer asks for one CAS-before-RAS (CBR) refresh per interval. If the access sequencer holds the memory bus, a pending counter lets several refreshes wait, and they are issued back to back once the bus is granted. If the backlog grows past its limit, the retention interval has been broken, so the block runs the wake-up burst again before it allows accesses.

The block shares the RAS and CAS strobes with an access sequencer through a request/grant pair. It raises `ref_req` whenever it needs the strobes. It starts a cycle only on a clock where `ref_gnt` is high, and it keeps `ref_req` high until that cycle's precharge has finished. Every refresh is formed by lowering CAS first and RAS second, so no address is needed and the data bus is never driven.

On request, the block enters self refresh. It starts a CBR cycle and keeps both strobes low beyond a minimum time, after which the device refreshes itself. When the request drops, RAS is raised and held high for an exit precharge. If the host reports that its own refresh before this point was not distributed, a full sweep of one CBR per row follows before accesses resume.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and for PAUSE_CYC cycles after it, `ras_n` and `cas_n` stay high, `ref_req` is low, `init_done` is low and `host_stall` is high.
- R2: After the pause, exactly WAKE_CYC CBR cycles are issued before `init_done` rises. The rise comes no sooner than PAUSE_CYC + WAKE_CYC·(CAS_LEAD+RAS_LOW+RP) cycles after reset.
- R3: Every cycle is CBR. `cas_n` is low for at least CAS_LEAD cycles before `ras_n` falls. `ras_n` then stays low for at least RAS_LOW cycles. Both strobes stay high for at least RP cycles before the next `cas_n` fall.
- R4: `cas_n` falls only on a clock where `ref_gnt` is high. `ref_req` stays high while either strobe is low. No strobe moves while the grant is withheld.
- R5: In normal operation with the grant available, one CBR refresh is issued per PRESCALE·DIV cycles.
- R6: While the grant is withheld, up to PEND_MAX refreshes are held pending. They are issued back to back when the grant returns, and `init_done` stays high.
- R7: An interval tick that arrives with PEND_MAX refreshes already pending drops `init_done`. The block then repeats the WAKE_CYC wake-up burst and raises `init_done` again.
- R8: With `sr_req` high in normal operation, the block starts a CBR cycle and holds both strobes low. `sr_active` rises after RAS has been low for SR_MIN cycles, and it stays high while `sr_req` stays high, with no further RAS edges.
- R9: After `sr_req` drops, `ras_n` rises. `host_stall` stays high for SR_RP cycles counted from the first cycle in which `ras_n` is high. When `need_full_sweep` is low, `host_stall` falls on the next cycle.
- R10: If `need_full_sweep` is high when the exit precharge ends, exactly ROWS CBR cycles follow before `host_stall` falls. If it is low, no cycle follows.
- R11: `host_stall` is high in every phase other than normal operation: the pause, the wake-up burst, self refresh and recovery. It is low in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Strobe ownership granted by the access sequencer |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| need_full_sweep | input | 1 | Prior refresh was not distributed; sweep all rows after self-refresh exit |
| ref_req | output | 1 | Request for strobe ownership |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | Wake-up burst has completed |
| host_stall | output | 1 | Host accesses must be held off |
| sr_active | output | 1 | Device is held in self refresh |

## Verification
A wrong internal count in this block shows at the ports as a wrong number of RAS falls between two easily seen events: the end of the pause and the rise of `init_done`, the grant returning and the backlog draining, or the self-refresh exit and the fall of `host_stall`. Each of those counts is checked exactly. An off-by-one in the phase counters changes the strobe widths or the cycle at which `host_stall` falls, which is visible within one refresh cycle. A broken pending limit shows within a few intervals, because `init_done` drops when it should not or stays high when it should drop.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_WAKE,
        ST_RUN,
        ST_SELF,
        ST_RECOVER
    } sched_st_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAS_LEAD,
        PH_RAS_ACT,
        PH_PRECH
    } phase_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned drs_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned drs_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer
    import drs_pkg::*;
#(
    parameter int unsigned PRESCALE = 50,
    parameter int unsigned DIV      = 39
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick_o
);
    localparam int unsigned PW = drs_width(PRESCALE - 1);
    localparam int unsigned DW = drs_width(DIV - 1);

    logic [PW-1:0] pre_q;
    logic [DW-1:0] div_q;
    logic          pre_wrap;
    logic          div_wrap;

    assign pre_wrap = (pre_q == PW'(PRESCALE - 1));
    assign div_wrap = (div_q == DW'(DIV - 1));
    assign tick_o   = pre_wrap && div_wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            div_q <= div_wrap ? '0 : div_q + DW'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/drs_pending_ctr.sv
module drs_pending_ctr
    import drs_pkg::*;
#(
    parameter int unsigned PEND_MAX = 4,
    localparam int unsigned NW = drs_width(PEND_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [NW-1:0] cnt_o,
    output logic          ovf_o
);
    logic [NW-1:0] cnt_q;
    logic          full;

    assign full  = (cnt_q == NW'(PEND_MAX));
    assign cnt_o = cnt_q;
    assign ovf_o = inc && !dec && full && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !dec && !full) begin
            cnt_q <= cnt_q + NW'(1);
        end else if (dec && !inc && (cnt_q != '0)) begin
            cnt_q <= cnt_q - NW'(1);
        end
    end
endmodule

// File: rtl/drs_strobe_gen.sv
module drs_strobe_gen
    import drs_pkg::*;
#(
    parameter int unsigned CAS_LEAD = 2,
    parameter int unsigned RAS_LOW  = 8,
    parameter int unsigned RP       = 5,
    parameter int unsigned SR_MIN   = 12500,
    parameter int unsigned SR_RP    = 14
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    self_i,
    input  logic    hold_i,
    output strobe_t stb_o,
    output logic    idle_o,
    output logic    done_o,
    output logic    in_self_o
);
    localparam int unsigned CMAX = drs_max(drs_max(CAS_LEAD, RAS_LOW),
                                           drs_max(drs_max(RP, SR_MIN), SR_RP));
    localparam int unsigned CW = drs_width(CMAX);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;
    logic          self_q;
    logic          cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign idle_o    = (ph_q == PH_IDLE);
    assign done_o    = (ph_q == PH_PRECH) && cnt_zero;
    assign in_self_o = (ph_q == PH_RAS_ACT) && self_q && cnt_zero;

    always_comb begin
        stb_o.ras_n = !(ph_q == PH_RAS_ACT);
        stb_o.cas_n = !((ph_q == PH_CAS_LEAD) || (ph_q == PH_RAS_ACT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            self_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        ph_q   <= PH_CAS_LEAD;
                        cnt_q  <= CW'(CAS_LEAD - 1);
                        self_q <= self_i;
                    end
                end
                PH_CAS_LEAD: begin
                    if (cnt_zero) begin
                        ph_q  <= PH_RAS_ACT;
                        cnt_q <= self_q ? CW'(SR_MIN - 1) : CW'(RAS_LOW - 1);
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_RAS_ACT: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - CW'(1);
                    end else if (!(self_q && hold_i)) begin
                        ph_q  <= PH_PRECH;
                        cnt_q <= self_q ? CW'(SR_RP - 1) : CW'(RP - 1);
                    end
                end
                PH_PRECH: begin
                    if (cnt_zero) begin
                        ph_q   <= PH_IDLE;
                        self_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 25000,
    parameter int unsigned WAKE_CYC  = 8,
    parameter int unsigned PRESCALE  = 50,
    parameter int unsigned DIV       = 39,
    parameter int unsigned PEND_MAX  = 4,
    parameter int unsigned CAS_LEAD  = 2,
    parameter int unsigned RAS_LOW   = 8,
    parameter int unsigned RP        = 5,
    parameter int unsigned SR_MIN    = 12500,
    parameter int unsigned SR_RP     = 14,
    parameter int unsigned ROWS      = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    input  logic sr_req,
    input  logic need_full_sweep,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic init_done,
    output logic host_stall,
    output logic sr_active
);
    localparam int unsigned PW  = drs_width(PAUSE_CYC - 1);
    localparam int unsigned CYW = drs_width(drs_max(WAKE_CYC, ROWS));
    localparam int unsigned PNW = drs_width(PEND_MAX);

    sched_st_t      state_q, state_d;
    logic [PW-1:0]  pause_q, pause_d;
    logic [CYW-1:0] cyc_q, cyc_d;
    logic [PNW-1:0] pend_cnt;
    logic           tick, ovf, run_clr, pend_dec;
    logic           gen_start, gen_self, gen_idle, gen_done, gen_in_self;
    strobe_t        stb;

    assign run_clr  = (state_q != ST_RUN);
    assign pend_dec = gen_done && (state_q == ST_RUN);

    drs_interval_timer #(
        .PRESCALE (PRESCALE),
        .DIV      (DIV)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (run_clr),
        .tick_o (tick)
    );

    drs_pending_ctr #(
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk   (clk),
        .rst   (rst),
        .clr   (run_clr),
        .inc   (tick),
        .dec   (pend_dec),
        .cnt_o (pend_cnt),
        .ovf_o (ovf)
    );

    drs_strobe_gen #(
        .CAS_LEAD (CAS_LEAD),
        .RAS_LOW  (RAS_LOW),
        .RP       (RP),
        .SR_MIN   (SR_MIN),
        .SR_RP    (SR_RP)
    ) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start_i   (gen_start),
        .self_i    (gen_self),
        .hold_i    (sr_req),
        .stb_o     (stb),
        .idle_o    (gen_idle),
        .done_o    (gen_done),
        .in_self_o (gen_in_self)
    );

    always_comb begin
        state_d   = state_q;
        pause_d   = pause_q;
        cyc_d     = cyc_q;
        gen_start = 1'b0;
        gen_self  = 1'b0;
        case (state_q)
            ST_PAUSE: begin
                if (pause_q == PW'(PAUSE_CYC - 1)) begin
                    state_d = ST_WAKE;
                    cyc_d   = '0;
                end else begin
                    pause_d = pause_q + PW'(1);
                end
            end
            ST_WAKE: begin
                gen_start = gen_idle && ref_gnt;
                if (gen_done) begin
                    if (cyc_q == CYW'(WAKE_CYC - 1)) begin
                        state_d = ST_RUN;
                        cyc_d   = '0;
                    end else begin
                        cyc_d = cyc_q + CYW'(1);
                    end
                end
            end
            ST_RUN: begin
                if (ovf) begin
                    state_d = ST_WAKE;
                    cyc_d   = '0;
                end else if (gen_idle && ref_gnt) begin
                    if (sr_req) begin
                        gen_start = 1'b1;
                        gen_self  = 1'b1;
                        state_d   = ST_SELF;
                    end else if (pend_cnt != '0) begin
                        gen_start = 1'b1;
                    end
                end
            end
            ST_SELF: begin
                if (gen_done) begin
                    cyc_d   = '0;
                    state_d = need_full_sweep ? ST_RECOVER : ST_RUN;
                end
            end
            ST_RECOVER: begin
                gen_start = gen_idle && ref_gnt;
                if (gen_done) begin
                    if (cyc_q == CYW'(ROWS - 1)) begin
                        state_d = ST_RUN;
                        cyc_d   = '0;
                    end else begin
                        cyc_d = cyc_q + CYW'(1);
                    end
                end
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
            pause_q <= '0;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            pause_q <= pause_d;
            cyc_q   <= cyc_d;
        end
    end

    assign ref_req = (state_q == ST_WAKE) || (state_q == ST_SELF) ||
                     (state_q == ST_RECOVER) || !gen_idle ||
                     ((state_q == ST_RUN) && ((pend_cnt != '0) || sr_req));
    assign ras_n      = stb.ras_n;
    assign cas_n      = stb.cas_n;
    assign init_done  = (state_q != ST_PAUSE) && (state_q != ST_WAKE);
    assign host_stall = (state_q != ST_RUN);
    assign sr_active  = gen_in_self;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int unsigned PEND_MAX = 4,
    parameter int unsigned RAS_LOW  = 8,
    parameter int unsigned PNW      = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           ras_n,
    input logic           cas_n,
    input logic           ref_req,
    input logic           ref_gnt,
    input logic           init_done,
    input logic           host_stall,
    input logic           sr_active,
    input logic [PNW-1:0] pend_cnt
);
    logic [15:0] low_len;

    always_ff @(posedge clk) begin
        if (rst || ras_n) begin
            low_len <= '0;
        end else if (low_len != 16'hFFFF) begin
            low_len <= low_len + 16'd1;
        end
    end

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !cas_n && $past(!cas_n)); // R3

    AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_len >= 16'(RAS_LOW))); // R3

    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $past(ref_gnt)); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cas_n || !ras_n) |-> ref_req); // R4

    AST_STALL_UNTIL_INIT: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> host_stall); // R11

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PNW'(PEND_MAX)); // R6

    AST_SELF_STROBES_LOW: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> !ras_n && !cas_n && host_stall); // R8
endmodule

bind dram_refresh_sched drs_checker #(
    .PEND_MAX (PEND_MAX),
    .RAS_LOW  (RAS_LOW),
    .PNW      (PNW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .ref_req    (ref_req),
    .ref_gnt    (ref_gnt),
    .init_done  (init_done),
    .host_stall (host_stall),
    .sr_active  (sr_active),
    .pend_cnt   (pend_cnt)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int PAUSE_CYC = 200;
    localparam int WAKE_CYC  = 8;
    localparam int PRESCALE  = 4;
    localparam int DIV       = 25;
    localparam int PEND_MAX  = 4;
    localparam int CAS_LEAD  = 2;
    localparam int RAS_LOW   = 4;
    localparam int RP        = 3;
    localparam int SR_MIN    = 10;
    localparam int SR_RP     = 6;
    localparam int ROWS      = 16;
    localparam int PERIOD    = PRESCALE * DIV;
    localparam int CYC_LEN   = CAS_LEAD + RAS_LOW + RP;

    logic clk = 1'b0;
    logic rst;
    logic follow, gnt_r, sr_req, need_full_sweep;
    logic ref_gnt, ref_req, ras_n, cas_n, init_done, host_stall, sr_active;

    int checks = 0;
    int errors = 0;

    int cyc_n, cbr_cnt, cas_low_run, ras_low_run, high_run;
    logic prev_ras, prev_cas;

    always #4 clk = ~clk;

    assign ref_gnt = follow ? ref_req : gnt_r;

    dram_refresh_sched #(
        .PAUSE_CYC (PAUSE_CYC), .WAKE_CYC (WAKE_CYC), .PRESCALE (PRESCALE),
        .DIV (DIV), .PEND_MAX (PEND_MAX), .CAS_LEAD (CAS_LEAD),
        .RAS_LOW (RAS_LOW), .RP (RP), .SR_MIN (SR_MIN), .SR_RP (SR_RP),
        .ROWS (ROWS)
    ) u0 (
        .clk (clk), .rst (rst), .ref_gnt (ref_gnt), .sr_req (sr_req),
        .need_full_sweep (need_full_sweep), .ref_req (ref_req),
        .ras_n (ras_n), .cas_n (cas_n), .init_done (init_done),
        .host_stall (host_stall), .sr_active (sr_active)
    );

    function automatic void chk(input bit ok, input string req, input string what,
                                input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    function automatic bit in_range(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // Strobe monitor: waveform rules R3 and grant rule R4
    always @(negedge clk) begin
        if (rst) begin
            cyc_n = 0; cbr_cnt = 0; cas_low_run = 0; ras_low_run = 0;
            high_run = 1000; prev_ras = 1'b1; prev_cas = 1'b1;
        end else begin
            cyc_n++;
            if (prev_ras && !ras_n) begin
                cbr_cnt++;
                chk(!cas_n && cas_low_run >= CAS_LEAD, "R3", "cas lead before ras fall",
                    cas_low_run, CAS_LEAD);
            end
            if (!prev_ras && ras_n)
                chk(ras_low_run >= RAS_LOW, "R3", "ras low width", ras_low_run, RAS_LOW);
            if (prev_cas && !cas_n) begin
                chk(high_run >= RP, "R3", "precharge width", high_run, RP);
                chk(ref_gnt == 1'b1, "R4", "grant at cycle start", ref_gnt, 1);
                chk(ref_req == 1'b1, "R4", "request during cycle", ref_req, 1);
            end
            cas_low_run = !cas_n ? cas_low_run + 1 : 0;
            ras_low_run = !ras_n ? ras_low_run + 1 : 0;
            high_run    = (ras_n && cas_n) ? high_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc_n, 0);
        finish_run();
    end

    initial begin
        int c0, k;
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; follow = 1'b1; gnt_r = 1'b0; sr_req = 1'b0; need_full_sweep = 1'b0;
        repeat (4) @(posedge clk);
        chk(ras_n && cas_n && !ref_req, "R1", "strobes idle in reset", {ras_n, cas_n, ref_req}, 3'b110);
        @(negedge clk); #1 rst = 1'b0;
        step(1);
        chk(!init_done && host_stall, "R1", "init_done/host_stall after reset",
            {init_done, host_stall}, 2'b01);
        chk(!ref_req, "R1", "no request after reset", ref_req, 0);

        while (cyc_n < PAUSE_CYC - 2) step(1);
        chk(cbr_cnt == 0 && ras_n && cas_n, "R1", "no refresh during pause", cbr_cnt, 0);
        chk(!init_done, "R1", "init_done low in pause", init_done, 0);

        while (cyc_n < PAUSE_CYC + 20) step(1);
        chk(host_stall && !init_done, "R11", "stall during wake burst",
            {init_done, host_stall}, 2'b01);

        k = 0;
        while (!init_done && k < 2000) begin step(1); k++; end
        chk(cbr_cnt == WAKE_CYC, "R2", "wake cycles before init_done", cbr_cnt, WAKE_CYC);
        chk(cyc_n >= PAUSE_CYC + WAKE_CYC * CYC_LEN, "R2", "init_done not early",
            cyc_n, PAUSE_CYC + WAKE_CYC * CYC_LEN);
        chk(!host_stall, "R11", "stall released in normal operation", host_stall, 0);

        // R5: distributed rate with grant following request
        c0 = cbr_cnt;
        step(10 * PERIOD);
        chk(in_range(cbr_cnt - c0, 9, 11), "R5", "refreshes in ten intervals", cbr_cnt - c0, 10);

        // R6: postpone while grant withheld, then catch up
        follow = 1'b0; gnt_r = 1'b0;
        step(20);
        c0 = cbr_cnt;
        step(320);
        chk(cbr_cnt == c0, "R4", "no strobes without grant", cbr_cnt - c0, 0);
        follow = 1'b1;
        step(60);
        chk(in_range(cbr_cnt - c0, 3, 5), "R6", "backlog issued after grant", cbr_cnt - c0, 4);
        chk(init_done, "R6", "init_done held through postponement", init_done, 1);

        // R7: overrun of the pending limit repeats the wake burst
        step(40);
        follow = 1'b0; gnt_r = 1'b0;
        step(20);
        c0 = cbr_cnt;
        step((PEND_MAX + 2) * PERIOD);
        chk(!init_done, "R7", "init_done dropped on overrun", init_done, 0);
        chk(host_stall, "R11", "stall during repeated wake", host_stall, 1);
        chk(cbr_cnt == c0, "R4", "no strobes while grant held off", cbr_cnt - c0, 0);
        follow = 1'b1;
        k = 0;
        while (!init_done && k < 2000) begin step(1); k++; end
        chk(cbr_cnt - c0 == WAKE_CYC, "R7", "repeated wake burst length", cbr_cnt - c0, WAKE_CYC);

        // Random grant pattern: waveform rules stay intact, no overrun
        follow = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            gnt_r = ($urandom % 4) != 0;
            step(1);
        end
        follow = 1'b1;
        step(40);
        chk(init_done && !host_stall, "R6", "no overrun under random grant",
            {init_done, host_stall}, 2'b10);

        // R8/R9: self refresh without sweep
        sr_req = 1'b1;
        k = 0;
        while (!sr_active && k < 400) begin step(1); k++; end
        chk(sr_active, "R8", "self refresh reached", sr_active, 1);
        chk(ras_low_run >= SR_MIN, "R8", "ras low before self refresh", ras_low_run, SR_MIN);
        chk(host_stall, "R11", "stall in self refresh", host_stall, 1);
        c0 = cbr_cnt;
        step(3 * PERIOD);
        chk(sr_active && !ras_n && !cas_n && cbr_cnt == c0, "R8", "held in self refresh",
            cbr_cnt - c0, 0);
        need_full_sweep = 1'b0;
        sr_req = 1'b0;
        while (!ras_n) step(1);
        c0 = cbr_cnt;
        k = 1;
        while (host_stall && k < 400) begin step(1); k++; end
        chk(k == SR_RP + 1, "R9", "stall release after exit precharge", k, SR_RP + 1);
        chk(cbr_cnt == c0, "R10", "no sweep when not requested", cbr_cnt - c0, 0);

        // R10: self refresh with full sweep on exit
        step(30);
        need_full_sweep = 1'b1;
        sr_req = 1'b1;
        k = 0;
        while (!sr_active && k < 400) begin step(1); k++; end
        step(20);
        sr_req = 1'b0;
        while (!ras_n) step(1);
        c0 = cbr_cnt;
        k = 0;
        while (host_stall && k < 2000) begin step(1); k++; end
        chk(cbr_cnt - c0 == ROWS, "R10", "sweep length after exit", cbr_cnt - c0, ROWS);
        chk(init_done, "R11", "init_done kept through self refresh", init_done, 1);
        need_full_sweep = 1'b0;
        step(2 * PERIOD);
        chk(!host_stall, "R11", "normal operation resumed", host_stall, 0);

        finish_run();
    end
endmodule